// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps one small status machine per hardware thread of a multithreaded instruction front end. Each cycle it folds in the control traffic that reaches the fetch stage: sticky stall requests from four downstream stages, squash requests from commit and decode, a hold while the reorder buffer is still squashing, a global context-switch stall, issue events for new cache requests, and tagged instruction-cache completions. From these it works out each thread's next state.

It reports each thread's state code, a per-thread flag that marks the fetched line as valid, a stage-active flag with one-cycle pulses when that flag changes, and a count of completions that were thrown away because they arrived late or did not match. The fetch datapath, branch prediction and the memory system sit outside and read these outputs.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is in Running, all stall bits are clear, `stage_active` is 1, both pulses are 0, `line_valid` is 0 and `miss_drop_count` is 0. State codes on `thread_state` (4 bits per thread, thread t at bits 4t+3..4t): Running 0, Idle 1, Squashing 2, Blocked 3, Fetching 4, TrapPending 5, QuiescePending 6, WaitResponse 7, WaitRetry 8, AccessComplete 9.
- R2: Each thread has one sticky stall bit per downstream stage. A pulse on `stall_set` bit s*NTHREADS+t (stage s: decode 0, rename 1, execute 2, commit 3) sets that bit, and a pulse on the same bit of `stall_clr` clears it. The bit holds its value in between. A set and a clear for the same bit in the same cycle are illegal.
- R3: A thread counts as stalled when `ctx_switch` is high or any of its stall bits is set after this cycle's updates. If no squash applies, a stalled thread enters Blocked on the next edge, unless it is in WaitResponse or WaitRetry. Those two states are kept.
- R4: A commit squash or a reorder-buffer-squashing flag for a thread puts it in Squashing on the next edge. This takes priority over every stall and event.
- R5: A decode squash puts a thread that is not already squashing into Squashing. A thread that is already in Squashing stays there for that cycle and does not return to Running. A decode squash also takes priority over stalls.
- R6: If no squash or stall applies, a thread in Blocked or Squashing returns to Running. Every other state is kept, unless an event under R7 or R9 applies.
- R7: An issue event (`iss_valid`, `iss_tid`, `iss_tag`) does the following. A Running thread moves to WaitResponse, or to WaitRetry when `iss_busy` is 1. Its tag is recorded and its `line_valid` is cleared. A thread in AccessComplete returns to Running. In all other states the event is ignored.
- R8: A completion (`cmp_valid`, `cmp_tid`, `cmp_tag`) is discarded in any of these cases: its thread is not in WaitResponse, its tag differs from the recorded one, or a squash or stall transition takes the thread this cycle. A discard increments `miss_drop_count` by one and leaves the thread's state and `line_valid` unchanged.
- R9: A completion that is accepted sets `line_valid` for its thread. The thread moves to Blocked if it is stalled, and to AccessComplete otherwise.
- R10: `stage_active` is 1 when any thread is in Running, Squashing or AccessComplete. `activate_pulse` is high for exactly the first cycle after that flag rises, and `deactivate_pulse` is high for exactly the first cycle after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_set | input | 4*NTHREADS | Per stage and thread block pulses |
| stall_clr | input | 4*NTHREADS | Per stage and thread unblock pulses |
| ctx_switch | input | 1 | Global context-switch stall |
| cmt_squash | input | NTHREADS | Squash from commit, per thread |
| rob_squashing | input | NTHREADS | Reorder buffer still squashing, per thread |
| dec_squash | input | NTHREADS | Squash from decode, per thread |
| iss_valid | input | 1 | Cache request issue event |
| iss_tid | input | TID_W | Thread of the issued request |
| iss_tag | input | TAG_W | Tag of the issued request |
| iss_busy | input | 1 | Cache port refused the request |
| cmp_valid | input | 1 | Cache completion event |
| cmp_tid | input | TID_W | Thread of the completion |
| cmp_tag | input | TAG_W | Tag of the completion |
| thread_state | output | 4*NTHREADS | Per-thread state codes |
| line_valid | output | NTHREADS | Fetched line valid, per thread |
| stage_active | output | 1 | Some thread can make progress |
| activate_pulse | output | 1 | Stage just became active |
| deactivate_pulse | output | 1 | Stage just became inactive |
| miss_drop_count | output | CNT_W | Discarded completions, wrapping |

## Verification
The bench goes after the priority ladder: decode squash in the same cycle as a new stall, commit squash on a blocked thread, and decode squash on a thread that is already squashing. A design with the wrong order would show Blocked or Running where Squashing is expected. It also checks that waiting threads are exempt from a stall, and that a completion arriving under a stall lands the thread in Blocked rather than AccessComplete. Late, mismatched and squash-coincident completions must each bump the drop count without touching state or the line flag. The activity pulses are checked across a full deactivate and reactivate, where a level-based or inverted design would pulse on every idle cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   localparam int NSTG = 4;

   typedef enum logic [3:0] {
      ST_RUN        = 4'd0,
      ST_IDLE       = 4'd1,
      ST_SQUASH     = 4'd2,
      ST_BLOCK      = 4'd3,
      ST_FETCH      = 4'd4,
      ST_TRAP       = 4'd5,
      ST_QUIESCE    = 4'd6,
      ST_WAIT_RESP  = 4'd7,
      ST_WAIT_RETRY = 4'd8,
      ST_ACC_DONE   = 4'd9
   } fsc_state_e;

   function automatic logic fsc_is_live(fsc_state_e s);
      return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_ACC_DONE);
   endfunction

endpackage

// File: rtl/fsc_stall_bits.sv
module fsc_stall_bits #(
   parameter int NSTG = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSTG-1:0] set_i,
   input  logic [NSTG-1:0] clr_i,
   output logic [NSTG-1:0] bits_q,
   output logic [NSTG-1:0] bits_d
);

   always_comb bits_d = (bits_q | set_i) & ~clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_d;
   end

   assert_set_clr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i & clr_i) == '0);

   assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((bits_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
   import fsc_pkg::*;
#(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmt_sq_i,
   input  logic             rob_sq_i,
   input  logic             dec_sq_i,
   input  logic             stalled_i,
   input  logic             iss_hit_i,
   input  logic             iss_busy_i,
   input  logic [TAG_W-1:0] iss_tag_i,
   input  logic             cmp_hit_i,
   input  logic [TAG_W-1:0] cmp_tag_i,
   output fsc_state_e       state_o,
   output logic             line_valid_o,
   output logic             drop_o
);

   fsc_state_e       st_q, st_d;
   logic [TAG_W-1:0] tag_q, tag_d;
   logic             lv_q, lv_d;
   logic             any_sq, waiting;

   always_comb begin
      any_sq  = cmt_sq_i | rob_sq_i | dec_sq_i;
      waiting = (st_q == ST_WAIT_RESP) || (st_q == ST_WAIT_RETRY);
      st_d    = st_q;
      tag_d   = tag_q;
      lv_d    = lv_q;
      drop_o  = 1'b0;
      if (any_sq) begin
         st_d   = ST_SQUASH;
         drop_o = cmp_hit_i;
      end else if (stalled_i && !waiting) begin
         st_d   = ST_BLOCK;
         drop_o = cmp_hit_i;
      end else if (st_q == ST_BLOCK || st_q == ST_SQUASH) begin
         st_d   = ST_RUN;
         drop_o = cmp_hit_i;
      end else if (cmp_hit_i) begin
         if (st_q == ST_WAIT_RESP && cmp_tag_i == tag_q) begin
            lv_d = 1'b1;
            st_d = stalled_i ? ST_BLOCK : ST_ACC_DONE;
         end else begin
            drop_o = 1'b1;
         end
      end else if (iss_hit_i) begin
         if (st_q == ST_RUN) begin
            st_d  = iss_busy_i ? ST_WAIT_RETRY : ST_WAIT_RESP;
            tag_d = iss_tag_i;
            lv_d  = 1'b0;
         end else if (st_q == ST_ACC_DONE) begin
            st_d = ST_RUN;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         tag_q <= '0;
         lv_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         tag_q <= tag_d;
         lv_q  <= lv_d;
      end
   end

   assign state_o      = st_q;
   assign line_valid_o = lv_q;

   assert_commit_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_sq_i || rob_sq_i) |=> (state_o == ST_SQUASH));

   assert_wait_exempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled_i && !any_sq && !cmp_hit_i && state_o == ST_WAIT_RESP)
      |=> (state_o == ST_WAIT_RESP));

   assert_line_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid_o) |-> (state_o == ST_ACC_DONE || state_o == ST_BLOCK));

endmodule

// File: rtl/fsc_activity.sv
module fsc_activity
   import fsc_pkg::*;
#(
   parameter int NTHREADS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [4*NTHREADS-1:0]     states_i,
   output logic                      active_o,
   output logic                      act_pulse_o,
   output logic                      deact_pulse_o
);

   logic [NTHREADS-1:0] live;
   logic                prev_q;

   for (genvar t = 0; t < NTHREADS; t++) begin : g_live
      assign live[t] = fsc_is_live(fsc_state_e'(states_i[4*t +: 4]));
   end

   assign active_o      = |live;
   assign act_pulse_o   = active_o & ~prev_q;
   assign deact_pulse_o = ~active_o & prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= active_o;
   end

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
   import fsc_pkg::*;
#(
   parameter int NTHREADS = 4,
   parameter int TAG_W    = 4,
   parameter int CNT_W    = 8,
   localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSTG*NTHREADS-1:0]  stall_set,
   input  logic [NSTG*NTHREADS-1:0]  stall_clr,
   input  logic                      ctx_switch,
   input  logic [NTHREADS-1:0]       cmt_squash,
   input  logic [NTHREADS-1:0]       rob_squashing,
   input  logic [NTHREADS-1:0]       dec_squash,
   input  logic                      iss_valid,
   input  logic [TID_W-1:0]          iss_tid,
   input  logic [TAG_W-1:0]          iss_tag,
   input  logic                      iss_busy,
   input  logic                      cmp_valid,
   input  logic [TID_W-1:0]          cmp_tid,
   input  logic [TAG_W-1:0]          cmp_tag,
   output logic [4*NTHREADS-1:0]     thread_state,
   output logic [NTHREADS-1:0]       line_valid,
   output logic                      stage_active,
   output logic                      activate_pulse,
   output logic                      deactivate_pulse,
   output logic [CNT_W-1:0]          miss_drop_count
);

   if (NTHREADS < 2) begin : g_bad_threads
      $error("fetch_status_ctrl: NTHREADS must be at least 2");
   end
   if (TAG_W < 1 || CNT_W < 1) begin : g_bad_widths
      $error("fetch_status_ctrl: TAG_W and CNT_W must be positive");
   end

   logic [NTHREADS-1:0] drop;

   for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
      logic [NSTG-1:0] set_v, clr_v, bits_q, bits_d;
      fsc_state_e      st;

      for (genvar s = 0; s < NSTG; s++) begin : g_stg
         assign set_v[s] = stall_set[s*NTHREADS + t];
         assign clr_v[s] = stall_clr[s*NTHREADS + t];
      end

      fsc_stall_bits #(.NSTG(NSTG)) u_stall (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v),
         .clr_i  (clr_v),
         .bits_q (bits_q),
         .bits_d (bits_d)
      );

      fsc_thread_fsm #(.TAG_W(TAG_W)) u_fsm (
         .clk          (clk),
         .rst_n        (rst_n),
         .cmt_sq_i     (cmt_squash[t]),
         .rob_sq_i     (rob_squashing[t]),
         .dec_sq_i     (dec_squash[t]),
         .stalled_i    (ctx_switch | (|bits_d)),
         .iss_hit_i    (iss_valid && (iss_tid == TID_W'(t))),
         .iss_busy_i   (iss_busy),
         .iss_tag_i    (iss_tag),
         .cmp_hit_i    (cmp_valid && (cmp_tid == TID_W'(t))),
         .cmp_tag_i    (cmp_tag),
         .state_o      (st),
         .line_valid_o (line_valid[t]),
         .drop_o       (drop[t])
      );

      assign thread_state[4*t +: 4] = st;
   end

   fsc_activity #(.NTHREADS(NTHREADS)) u_act (
      .clk           (clk),
      .rst_n         (rst_n),
      .states_i      (thread_state),
      .active_o      (stage_active),
      .act_pulse_o   (activate_pulse),
      .deact_pulse_o (deactivate_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     miss_drop_count <= '0;
      else if (|drop) miss_drop_count <= miss_drop_count + CNT_W'(1);
   end

   assert_drop_needs_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_drop_count != $past(miss_drop_count)) |-> $past(cmp_valid));

   assert_fall_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stage_active) |-> (deactivate_pulse && !activate_pulse));

   assert_rise_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage_active) |-> (activate_pulse && !deactivate_pulse));

endmodule

// File: tb/fetch_status_ctrl_bench.sv
module fetch_status_ctrl_bench;

   localparam int NT    = 4;
   localparam int TAG_W = 4;
   localparam int CNT_W = 8;
   localparam int TID_W = 2;

   localparam logic [3:0] RUN = 4'd0, SQ = 4'd2, BLK = 4'd3,
                          WRSP = 4'd7, WRTY = 4'd8, DONE = 4'd9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4*NT-1:0] stall_set, stall_clr;
   logic ctx_switch;
   logic [NT-1:0] cmt_squash, rob_squashing, dec_squash;
   logic iss_valid, iss_busy, cmp_valid;
   logic [TID_W-1:0] iss_tid, cmp_tid;
   logic [TAG_W-1:0] iss_tag, cmp_tag;
   logic [4*NT-1:0] thread_state;
   logic [NT-1:0] line_valid;
   logic stage_active, activate_pulse, deactivate_pulse;
   logic [CNT_W-1:0] miss_drop_count;

   always #2.5 clk = ~clk;

   fetch_status_ctrl u_fetch_status_ctrl (
      .clk(clk), .rst_n(rst_n), .stall_set(stall_set), .stall_clr(stall_clr),
      .ctx_switch(ctx_switch), .cmt_squash(cmt_squash), .rob_squashing(rob_squashing),
      .dec_squash(dec_squash), .iss_valid(iss_valid), .iss_tid(iss_tid),
      .iss_tag(iss_tag), .iss_busy(iss_busy), .cmp_valid(cmp_valid),
      .cmp_tid(cmp_tid), .cmp_tag(cmp_tag), .thread_state(thread_state),
      .line_valid(line_valid), .stage_active(stage_active),
      .activate_pulse(activate_pulse), .deactivate_pulse(deactivate_pulse),
      .miss_drop_count(miss_drop_count)
   );

   typedef struct {
      string            tag;
      logic [4*NT-1:0]  st;
      logic [NT-1:0]    lv;
      logic [CNT_W-1:0] cnt;
      logic             act, ap, dp;
   } exp_t;

   exp_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0]       es [NT];
   logic [NT-1:0]    elv;
   logic [CNT_W-1:0] ecnt;
   logic             eact, eap, edp;

   task automatic idle_inputs();
      stall_set = '0; stall_clr = '0; ctx_switch = 1'b0;
      cmt_squash = '0; rob_squashing = '0; dec_squash = '0;
      iss_valid = 1'b0; iss_tid = '0; iss_tag = '0; iss_busy = 1'b0;
      cmp_valid = 1'b0; cmp_tid = '0; cmp_tag = '0;
   endtask

   // driver: pushes the expected result of the inputs now applied
   task automatic cyc(string tag);
      exp_t e;
      e.tag = tag;
      e.st  = {es[3], es[2], es[1], es[0]};
      e.lv  = elv; e.cnt = ecnt; e.act = eact; e.ap = eap; e.dp = edp;
      sb_q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   // monitor: compares just after the edge that consumed the inputs
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (thread_state !== e.st || line_valid !== e.lv ||
                miss_drop_count !== e.cnt || stage_active !== e.act ||
                activate_pulse !== e.ap || deactivate_pulse !== e.dp) begin
               errors++;
               $display("FAIL %s: actual st=%h lv=%b cnt=%0d act=%b ap=%b dp=%b expected st=%h lv=%b cnt=%0d act=%b ap=%b dp=%b",
                        e.tag, thread_state, line_valid, miss_drop_count,
                        stage_active, activate_pulse, deactivate_pulse,
                        e.st, e.lv, e.cnt, e.act, e.ap, e.dp);
            end
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      for (int t = 0; t < NT; t++) es[t] = RUN;
      elv = '0; ecnt = '0; eact = 1'b1; eap = 1'b0; edp = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc("R1 reset state");

      stall_set[0*NT+0] = 1'b1; es[0] = BLK;
      cyc("R2 decode block sets stall, R3 blocked");
      cyc("R2 stall bit sticky");
      stall_set[1*NT+0] = 1'b1; stall_clr[0*NT+0] = 1'b1;
      cyc("R2 rename bit keeps thread blocked");
      stall_clr[1*NT+0] = 1'b1; es[0] = RUN;
      cyc("R6 blocked returns to running");

      ctx_switch = 1'b1; for (int t = 0; t < NT; t++) es[t] = BLK;
      eact = 1'b0; edp = 1'b1;
      cyc("R3 context switch blocks all, R10 deactivate");
      ctx_switch = 1'b1; edp = 1'b0;
      cyc("R10 no repeat pulse");
      for (int t = 0; t < NT; t++) es[t] = RUN;
      eact = 1'b1; eap = 1'b1;
      cyc("R10 activate pulse");
      eap = 1'b0;

      iss_valid = 1'b1; iss_tid = 2'd1; iss_tag = 4'd5; es[1] = WRSP;
      cyc("R7 issue to wait response");
      iss_valid = 1'b1; iss_tid = 2'd2; iss_tag = 4'd3; iss_busy = 1'b1; es[2] = WRTY;
      cyc("R7 busy issue to wait retry");
      ctx_switch = 1'b1; es[0] = BLK; es[3] = BLK; eact = 1'b0; edp = 1'b1;
      cyc("R3 waiting threads exempt from stall");
      ctx_switch = 1'b1; cmp_valid = 1'b1; cmp_tid = 2'd1; cmp_tag = 4'd5;
      es[1] = BLK; elv[1] = 1'b1; edp = 1'b0;
      cyc("R9 accepted completion under stall blocks");
      es[0] = RUN; es[1] = RUN; es[3] = RUN; eact = 1'b1; eap = 1'b1;
      cyc("R6 release, R10 activate");
      eap = 1'b0;

      cmp_valid = 1'b1; cmp_tid = 2'd1; cmp_tag = 4'd5; ecnt = 8'd1;
      cyc("R8 late completion dropped");
      iss_valid = 1'b1; iss_tid = 2'd1; iss_tag = 4'd6; es[1] = WRSP; elv[1] = 1'b0;
      cyc("R7 issue clears line valid");
      cmp_valid = 1'b1; cmp_tid = 2'd1; cmp_tag = 4'd2; ecnt = 8'd2;
      cyc("R8 tag mismatch dropped");
      cmp_valid = 1'b1; cmp_tid = 2'd1; cmp_tag = 4'd6; es[1] = DONE; elv[1] = 1'b1;
      cyc("R9 accepted completion to access complete");
      iss_valid = 1'b1; iss_tid = 2'd1; iss_tag = 4'd9; es[1] = RUN;
      cyc("R7 access complete back to running");
      iss_valid = 1'b1; iss_tid = 2'd2; iss_tag = 4'd1;
      cyc("R7 issue ignored in wait retry");

      cmt_squash[2] = 1'b1; es[2] = SQ;
      cyc("R4 commit squash");
      dec_squash[2] = 1'b1;
      cyc("R5 decode squash while squashing holds");
      es[2] = RUN;
      cyc("R6 squashing returns to running");

      dec_squash[0] = 1'b1; stall_set[3*NT+0] = 1'b1; es[0] = SQ;
      cyc("R5 decode squash beats stall");
      es[0] = BLK;
      cyc("R3 squashing thread blocked by stall");
      cmt_squash[0] = 1'b1; es[0] = SQ;
      cyc("R4 commit squash beats stall");
      rob_squashing[0] = 1'b1; stall_clr[3*NT+0] = 1'b1;
      cyc("R4 rob squashing holds");
      es[0] = RUN;
      cyc("R6 back to running");

      iss_valid = 1'b1; iss_tid = 2'd3; iss_tag = 4'd4; es[3] = WRSP;
      cyc("R7 issue thread 3");
      cmt_squash[3] = 1'b1; cmp_valid = 1'b1; cmp_tid = 2'd3; cmp_tag = 4'd4;
      es[3] = SQ; ecnt = 8'd3;
      cyc("R8 completion with squash dropped");
      es[3] = RUN;
      cyc("R6 thread 3 running");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule